// File: doc/BRIEF.md
# HDLC Frame Receiver with End-of-Frame Status

This block takes a serial HDLC bit stream, one bit per cycle in which the bit-enable strobe is high, and turns it into a sequence of FIFO write operations. It finds flags, removes the zeros the transmitter stuffed after runs of five ones, and packs the remaining bits into bytes, least significant bit first. It runs a bit-serial CRC-16-CCITT over every de-stuffed bit between flags.

Only payload bytes reach the FIFO. The two check bytes are held back and dropped. Each frame that is long enough ends with one status byte, tagged with the end-of-frame marker. That byte reports a checksum failure, a frame length that is not a whole number of bytes, or an abort after data was already delivered. The most recent status byte also stays visible on a dedicated output. A single flag may both close one frame and open the next.

Top module: `hdlc_rx_eof`

## Requirements
- R1: While reset is asserted and after its release, `fifo_we` and `fifo_eof` are 0 and `eof_status` is 0x00.
- R2: Flags with nothing between them (01111110 repeated) produce no FIFO write.
- R3: A 0 received directly after five consecutive 1s is removed from the data. Payload bytes made of long runs of ones, or equal to 0x7E, come out unchanged.
- R4: Payload bytes are assembled LSB first and written in arrival order with `fifo_eof` = 0. The last two complete bytes of a frame (the check sequence) are never written.
- R5: A frame of four or more complete bytes ends with exactly one status write with `fifo_eof` = 1. That write comes in the cycle after the last payload byte, which is itself written in the cycle after the closing flag's final bit.
- R6: Status bit 7 is 1 when the CRC register, started at 0xFFFF and advanced once per de-stuffed bit, differs from 0xF0B8 at the closing flag, and 0 otherwise.
- R7: Status bit 4 is 1 when the number of de-stuffed bits between the flags is not a multiple of 8. Status bits 5 and 3 to 0 are always 0.
- R8: A frame whose closing flag is immediately followed by the next frame's data is accepted, and so is that next frame. The one flag serves as both closing and opening flag.
- R9: A frame with fewer than four complete bytes between flags produces no FIFO write at all.
- R10: Seven consecutive 1s abort the frame in progress. If payload bytes of that frame were already written, a single status byte 0x40 is written with `fifo_eof` = 1; otherwise nothing is written. Bits after an abort are ignored until the next flag.
- R11: `eof_status` takes the value of every status byte in the cycle it is written and holds it until the next status write.
- R12: While `bit_en` is 0, the value on `rx_bit` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Serial line bit |
| fifo_we | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Payload byte or status byte |
| fifo_eof | output | 1 | Marks the written byte as the end-of-frame status |
| eof_status | output | 8 | Most recent status byte |

## Verification
The bench targets frames whose payload is all ones or equals the flag pattern. A receiver that kept the stuffed zeros, or took data for a flag, would deliver shifted bytes or cut the frame short. Frames joined by a single flag test whether the closing flag also opens the next frame; getting this wrong drops the second frame. Two- and three-byte frames must leave the FIFO untouched, where a careless holdback would leak their first byte. Frames with trailing odd bits, or with a corrupted check sequence, must set bit 4 or bit 7 respectively. An abort after three delivered bytes must close the stream with 0x40, after which junk data must be ignored until a new flag arrives.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;
  localparam logic [15:0] CRC_GOOD = 16'hF0B8;
  localparam int ST_BAD_CRC = 7;
  localparam int ST_ABORT = 6;
  localparam int ST_BAD_LEN = 4;

  // One LSB-first step of the reflected CCITT polynomial.
  function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[15:1]} ^ (fb ? CRC_POLY_REF : 16'h0000);
  endfunction

  // Builds the end-of-frame status byte from its three flags.
  function automatic logic [BYTE_W-1:0] eof_code(input logic bad_crc, input logic bad_len,
                                                 input logic aborted);
    logic [BYTE_W-1:0] st;
    st = '0;
    st[ST_BAD_CRC] = bad_crc;
    st[ST_BAD_LEN] = bad_len;
    st[ST_ABORT] = aborted;
    return st;
  endfunction
endpackage

// File: rtl/hdlc_rx_flagdet.sv
module hdlc_rx_flagdet #(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  output logic flag_hit,
  output logic abort_hit,
  output logic dbit_vld,
  output logic dbit
);
  localparam int FLAG_RUN = STUFF_RUN + 1;
  localparam int CNT_W = $clog2(FLAG_RUN + 2);
  localparam logic [CNT_W-1:0] RUN_STUFF = CNT_W'(STUFF_RUN);
  localparam logic [CNT_W-1:0] RUN_FLAG = CNT_W'(FLAG_RUN);

  logic [CNT_W-1:0] ones_q;
  logic stuffed;

  always_comb begin
    flag_hit  = bit_en && !rx_bit && (ones_q == RUN_FLAG);
    stuffed   = bit_en && !rx_bit && (ones_q == RUN_STUFF);
    abort_hit = bit_en && rx_bit && (ones_q == RUN_FLAG);
    dbit_vld  = bit_en && !flag_hit && !stuffed && !(rx_bit && (ones_q >= RUN_FLAG));
    dbit      = rx_bit;
  end

  // Run length of ones, saturating one past the flag run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else if (bit_en) begin
      if (!rx_bit) ones_q <= '0;
      else if (ones_q <= RUN_FLAG) ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
  import hdlc_rx_pkg::*;
#(
  parameter int FLAG_LEN = 8,
  parameter int FCS_BYTES = 2,
  parameter int MIN_FRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_hit,
  input  logic              abort_hit,
  input  logic              dbit_vld,
  input  logic              dbit,
  output logic              fifo_we,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_eof,
  output logic [BYTE_W-1:0] eof_status,
  output logic              frame_close
);
  localparam int DLY = FLAG_LEN - 1;
  localparam int HOLD = FCS_BYTES + 1;
  localparam int FILL_W = $clog2(DLY + 1);
  localparam int NB_W = $clog2(MIN_FRAME_BYTES + 1);
  localparam int POS_W = $clog2(BYTE_W);
  localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(DLY);
  localparam logic [NB_W-1:0] NB_HOLD = NB_W'(HOLD);
  localparam logic [NB_W-1:0] NB_WROTE = NB_W'(HOLD + 1);
  localparam logic [NB_W-1:0] NB_MIN = NB_W'(MIN_FRAME_BYTES);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BYTE_W - 1);

  logic              in_frame_q;
  logic [FILL_W-1:0] fill_q;
  logic [DLY-1:0]    dly_q;
  logic [BYTE_W-2:0] sr_q;
  logic [POS_W-1:0]  bitpos_q;
  logic [NB_W-1:0]   nbyte_q;
  logic [15:0]       crc_q;
  logic [BYTE_W-1:0] hold_q [HOLD];
  logic              pend_q;
  logic [BYTE_W-1:0] pend_st_q;

  logic              commit, cbit, byte_full, abort_dump;
  logic [BYTE_W-1:0] new_byte;

  always_comb begin
    commit      = dbit_vld && in_frame_q && (fill_q == FILL_FULL);
    cbit        = dly_q[DLY-1];
    byte_full   = commit && (bitpos_q == POS_LAST);
    new_byte    = {cbit, sr_q};
    frame_close = flag_hit && in_frame_q && (nbyte_q >= NB_MIN);
    abort_dump  = abort_hit && in_frame_q && (nbyte_q >= NB_WROTE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      fill_q     <= '0;
      dly_q      <= '0;
      sr_q       <= '0;
      bitpos_q   <= '0;
      nbyte_q    <= '0;
      crc_q      <= CRC_INIT;
      for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
      pend_q     <= 1'b0;
      pend_st_q  <= '0;
      fifo_we    <= 1'b0;
      fifo_data  <= '0;
      fifo_eof   <= 1'b0;
      eof_status <= '0;
    end else begin
      fifo_we  <= 1'b0;
      fifo_eof <= 1'b0;
      if (pend_q) begin
        fifo_we    <= 1'b1;
        fifo_eof   <= 1'b1;
        fifo_data  <= pend_st_q;
        eof_status <= pend_st_q;
        pend_q     <= 1'b0;
      end
      if (flag_hit) begin
        if (frame_close) begin
          fifo_we   <= 1'b1;
          fifo_data <= hold_q[FCS_BYTES];
          pend_q    <= 1'b1;
          pend_st_q <= eof_code(crc_q != CRC_GOOD, bitpos_q != '0, 1'b0);
        end
        in_frame_q <= 1'b1;
        fill_q     <= '0;
        bitpos_q   <= '0;
        nbyte_q    <= '0;
        crc_q      <= CRC_INIT;
      end else if (abort_hit) begin
        if (abort_dump) begin
          fifo_we    <= 1'b1;
          fifo_eof   <= 1'b1;
          fifo_data  <= eof_code(1'b0, 1'b0, 1'b1);
          eof_status <= eof_code(1'b0, 1'b0, 1'b1);
        end
        in_frame_q <= 1'b0;
      end else if (dbit_vld && in_frame_q) begin
        dly_q <= {dly_q[DLY-2:0], dbit};
        if (fill_q != FILL_FULL) fill_q <= fill_q + 1'b1;
        if (commit) begin
          crc_q    <= crc16_bit(crc_q, cbit);
          sr_q     <= new_byte[BYTE_W-1:1];
          bitpos_q <= bitpos_q + 1'b1;
          if (byte_full) begin
            hold_q[0] <= new_byte;
            for (int i = 1; i < HOLD; i++) hold_q[i] <= hold_q[i-1];
            if (nbyte_q >= NB_HOLD) begin
              fifo_we   <= 1'b1;
              fifo_data <= hold_q[HOLD-1];
            end
            if (nbyte_q != NB_MIN) nbyte_q <= nbyte_q + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_eof.sv
module hdlc_rx_eof
  import hdlc_rx_pkg::*;
#(
  parameter int STUFF_RUN = 5,
  parameter int FCS_BYTES = 2,
  parameter int MIN_FRAME_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              rx_bit,
  output logic              fifo_we,
  output logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_eof,
  output logic [BYTE_W-1:0] eof_status
);
  localparam int FLAG_LEN = STUFF_RUN + 3;

  logic flag_hit, abort_hit, dbit_vld, dbit, frame_close;

  hdlc_rx_flagdet #(.STUFF_RUN(STUFF_RUN)) u_flagdet (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .flag_hit(flag_hit), .abort_hit(abort_hit), .dbit_vld(dbit_vld), .dbit(dbit)
  );

  hdlc_rx_framer #(
    .FLAG_LEN(FLAG_LEN), .FCS_BYTES(FCS_BYTES), .MIN_FRAME_BYTES(MIN_FRAME_BYTES)
  ) u_framer (
    .clk(clk), .rst_n(rst_n), .flag_hit(flag_hit), .abort_hit(abort_hit),
    .dbit_vld(dbit_vld), .dbit(dbit), .fifo_we(fifo_we), .fifo_data(fifo_data),
    .fifo_eof(fifo_eof), .eof_status(eof_status), .frame_close(frame_close)
  );
endmodule

// File: rtl/hdlc_rx_eof_chk.sv
module hdlc_rx_eof_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       flag_hit,
  input logic       abort_hit,
  input logic       dbit_vld,
  input logic       frame_close,
  input logic       fifo_we,
  input logic [7:0] fifo_data,
  input logic       fifo_eof,
  input logic [7:0] eof_status
);
  p_eof_needs_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_eof |-> fifo_we);

  p_close_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_close |=> (fifo_we && !fifo_eof));

  p_close_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_close, 2) |-> (fifo_we && fifo_eof));

  p_status_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && fifo_eof) |-> ((fifo_data & 8'h2F) == 8'h00));

  p_status_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_we && fifo_eof) |-> (eof_status == fifo_data));

  p_status_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_we && fifo_eof) |-> $stable(eof_status));

  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!fifo_we || fifo_eof));

  p_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> !(flag_hit || abort_hit || dbit_vld));
endmodule

bind hdlc_rx_eof hdlc_rx_eof_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .flag_hit(flag_hit),
  .abort_hit(abort_hit), .dbit_vld(dbit_vld), .frame_close(frame_close),
  .fifo_we(fifo_we), .fifo_data(fifo_data), .fifo_eof(fifo_eof),
  .eof_status(eof_status)
);

// File: tb/tb_hdlc_rx_eof.sv
module tb_hdlc_rx_eof;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b0;
  logic fifo_we, fifo_eof;
  logic [7:0] fifo_data, eof_status;

  always #4 clk = ~clk;

  hdlc_rx_eof dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .fifo_we(fifo_we), .fifo_data(fifo_data), .fifo_eof(fifo_eof), .eof_status(eof_status)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] cap_d [512];
  logic       cap_e [512];
  int n_cap = 0;
  logic [7:0] exp_d [512];
  logic       exp_e [512];
  int n_exp = 0, chk_ptr = 0;
  logic [7:0] exp_stat = 8'h00;
  int tx_ones = 0, gap_sel = 0;

  // {payload bytes, seed, step, extra bits, corrupt, shared flag, pad}
  localparam logic [31:0] VEC [9] = '{
    {8'd2, 8'h11, 8'h22, 4'd0, 1'b0, 1'b0, 2'b0},  // R4 shortest legal frame
    {8'd4, 8'hFF, 8'h00, 4'd0, 1'b0, 1'b0, 2'b0},  // R3 all ones
    {8'd3, 8'h7E, 8'h00, 4'd0, 1'b0, 1'b1, 2'b0},  // R3 flag-like data, R8 next
    {8'd5, 8'h30, 8'h0D, 4'd0, 1'b1, 1'b1, 2'b0},  // R6 corrupted, R8 next
    {8'd6, 8'hA5, 8'h13, 4'd3, 1'b0, 1'b0, 2'b0},  // R7 odd tail
    {8'd1, 8'h40, 8'h00, 4'd0, 1'b0, 1'b0, 2'b0},  // R9 three bytes
    {8'd0, 8'h00, 8'h00, 4'd0, 1'b0, 1'b0, 2'b0},  // R9 two bytes
    {8'd7, 8'h01, 8'h02, 4'd5, 1'b0, 1'b1, 2'b0},  // R7 odd tail, R8 next
    {8'd9, 8'hC3, 8'h3C, 4'd0, 1'b0, 1'b0, 2'b0}   // R4 longer frame
  };

  always @(negedge clk) begin
    if (rst_n && fifo_we) begin
      if (n_cap < 512) begin
        cap_d[n_cap] = fifo_data;
        cap_e[n_cap] = fifo_eof;
      end
      n_cap++;
    end
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic b);
    return (c >> 1) ^ ({16{c[0] ^ b}} & 16'h8408);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One qualified bit, then idle cycles with junk on the line (R12).
  task automatic raw_bit(input logic b);
    bit_en = 1'b1;
    rx_bit = b;
    @(negedge clk);
    bit_en = 1'b0;
    rx_bit = ~b;
    repeat (gap_sel % 3) begin
      @(negedge clk);
      rx_bit = ~rx_bit;
    end
    gap_sel++;
  endtask

  task automatic tx_bit(input logic b);
    raw_bit(b);
    tx_ones = b ? tx_ones + 1 : 0;
    if (tx_ones == 5) begin
      raw_bit(1'b0);
      tx_ones = 0;
    end
  endtask

  task automatic tx_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_bit(v[i]);
  endtask

  task automatic tx_flag();
    raw_bit(1'b0);
    for (int i = 0; i < 6; i++) raw_bit(1'b1);
    raw_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic raw_ones(input int n);
    for (int i = 0; i < n; i++) raw_bit(1'b1);
    tx_ones = 0;
  endtask

  task automatic push_exp(input logic [7:0] d, input logic e);
    exp_d[n_exp] = d;
    exp_e[n_exp] = e;
    n_exp++;
  endtask

  task automatic send_frame(input int n, input logic [7:0] seed, input logic [7:0] step,
                            input int extra, input bit corrupt);
    logic [15:0] c, fcs;
    logic [7:0] d;
    int start;
    start = n_exp;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      d = 8'(int'(seed) + int'(step) * i);
      for (int k = 0; k < 8; k++) c = ref_crc(c, d[k]);
      tx_byte(d);
      push_exp(d, 1'b0);
    end
    fcs = ~c;
    if (corrupt) fcs = fcs ^ 16'h0008;
    for (int k = 0; k < 16; k++) c = ref_crc(c, fcs[k]);
    tx_byte(fcs[7:0]);
    tx_byte(fcs[15:8]);
    for (int k = 0; k < extra; k++) begin
      c = ref_crc(c, (k % 2) == 0);
      tx_bit((k % 2) == 0);
    end
    tx_flag();
    if (n + 2 < 4) n_exp = start;
    else begin
      exp_stat = {c != 16'hF0B8, 2'b00, extra != 0, 4'b0000};
      push_exp(exp_stat, 1'b1);
    end
  endtask

  task automatic verify(input string tag);
    repeat (6) @(negedge clk);
    check(n_cap == n_exp, {tag, " write count"}, n_cap, n_exp);
    for (int i = chk_ptr; i < n_exp && i < n_cap; i++)
      check(cap_d[i] == exp_d[i] && cap_e[i] == exp_e[i],
            exp_e[i] ? "R5 R6 R7 status byte" : "R3 R4 payload byte",
            {cap_e[i], cap_d[i]}, {exp_e[i], exp_d[i]});
    check(eof_status == exp_stat, "R11 held status", eof_status, exp_stat);
    n_cap = n_exp;
    chk_ptr = n_exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (R1) actual=%0d expected=%0d", n_cap, n_exp);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(fifo_we == 1'b0 && fifo_eof == 1'b0, "R1 strobes in reset", fifo_we, 0);
    check(eof_status == 8'h00, "R1 status in reset", eof_status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(fifo_we == 1'b0 && eof_status == 8'h00, "R1 after release", eof_status, 0);

    raw_ones(10);
    tx_flag();
    tx_flag();
    tx_flag();
    verify("R2 idle flags");

    for (int v = 0; v < 9; v++) begin
      send_frame(int'(VEC[v][31:24]), VEC[v][23:16], VEC[v][15:8],
                 int'(VEC[v][7:4]), VEC[v][3]);
      verify((v > 0 && VEC[v-1][2]) ? "R8 shared flag" : "R9 frame");
      if (!VEC[v][2]) begin
        raw_ones(10);
        tx_flag();
      end
    end

    // R10: abort after three payload bytes were delivered.
    for (int i = 0; i < 6; i++) begin
      tx_byte(8'(8'h21 + 8'h11 * i));
      if (i < 3) push_exp(8'(8'h21 + 8'h11 * i), 1'b0);
    end
    tx_byte(8'h00);
    raw_ones(8);
    exp_stat = 8'h40;
    push_exp(8'h40, 1'b1);
    verify("R10 abort with data");

    // R10: data after the abort, with no new flag, stays ignored.
    tx_byte(8'h00);
    tx_byte(8'h5A);
    tx_byte(8'h00);
    verify("R10 hunting after abort");

    // R10: abort before any payload was written.
    tx_flag();
    tx_byte(8'h12);
    tx_byte(8'h34);
    raw_ones(8);
    verify("R10 early abort");

    // R12: a full frame on rx_bit with bit_en low.
    for (int i = 0; i < 120; i++) begin
      rx_bit = (i % 9) != 0;
      @(negedge clk);
    end
    verify("R12 gated input");

    tx_flag();
    send_frame(2, 8'h5A, 8'h11, 0, 1'b0);
    verify("R10 recovery frame");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule